// File: doc/BRIEF.md
# Flash ECC Fault Reporting Controller

This block sits beside a flash array controller and turns its per-read ECC detect pulses into sticky status, a capture of the first faulting read, and level interrupts. Each completed array read presents its address, its data and two detect bits, one for a correctable single-bit fault and one for an uncorrectable double-bit fault. A command-done pulse from the command sequencer sets a command-complete flag that can also raise an interrupt.

Software reaches the block through a small byte-wide register port. A control register holds three interrupt enables and a switch that suppresses single-bit reporting. A separate injection register forces either fault flag on every array read, which lets the interrupt routines be tested without corrupting the capture registers. Status flags are cleared by writing 1. The capture registers are read back byte by byte.

Top module: `ecc_fault_reporter`

## Requirements
- R1: After reset every register reads 0x00 and the three interrupt outputs are low.
- R2: Register index 0 (control) keeps bit 7 = command-complete enable, bit 4 = ignore single faults, bit 1 = double-fault enable and bit 0 = single-fault enable; its other bits read 0. Index 1 (injection) keeps bit 1 = force double and bit 0 = force single; its other bits read 0. Index 3 reads 0.
- R3: A cmd_done pulse sets status (index 2) bit 7. irq_cmd is high exactly while that flag and control bit 7 are both 1.
- R4: With control bit 4 at 0, a read with the single detect set (double detect clear) sets status bit 0. With bit 4 at 1, such a read changes neither that flag, the interrupt nor the capture registers.
- R5: A read that reports both single and double detect sets status bit 1 and does not set status bit 0.
- R6: While injection bit 1 (or bit 0) is 1, every array read sets status bit 1 (or bit 0), even with no detect and even with control bit 4 set. The injection bits stay set until software writes them to 0.
- R7: Only the first genuine fault (a real double detect, or a real single detect that is not ignored) after status bits 1 and 0 are both clear loads the capture registers: index 4 = address bits 7:0, index 5 = address bits 15:8, index 6 = data bits 7:0, index 7 = data bits 15:8. Forced flags never load them.
- R8: Writing 1 to a status bit clears it; writing 0 leaves it. A flag set by an event in the same cycle as its clear stays set.
- R9: irq_dbl equals status bit 1 AND control bit 1; irq_sgl equals status bit 0 AND control bit 0. Each interrupt is low in the cycle after the write that clears its flag.
- R10: reg_rdata shows the register selected by reg_ridx one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_widx | input | RIDX_W | Register index for the write |
| reg_wdata | input | 8 | Write data |
| reg_ridx | input | RIDX_W | Register index for the read |
| reg_rdata | output | 8 | Registered read data |
| arr_rd_valid | input | 1 | One array read completed this cycle |
| arr_rd_addr | input | CAP_AW | Address of that read |
| arr_rd_data | input | CAP_DW | Data of that read |
| arr_sgl_det | input | 1 | Single-bit fault detected on that read |
| arr_dbl_det | input | 1 | Double-bit fault detected on that read |
| cmd_done | input | 1 | Flash command finished (pulse) |
| irq_cmd | output | 1 | Command-complete interrupt (level) |
| irq_dbl | output | 1 | Double-fault interrupt (level) |
| irq_sgl | output | 1 | Single-fault interrupt (level) |

## Verification
Every flag, capture register and interrupt changes at the clock edge that samples its cause, so an interrupt is visible right after the edge that takes a read, a command-done pulse or a clearing write; register contents appear on reg_rdata one edge after the index is driven. The driver applies each stimulus for one cycle and queues its expected value tagged with the cycle it is due, and the monitor compares only at the falling edge of that cycle. Interrupt checks after clearing writes are queued for the very next cycle to pin down the one-cycle drop.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  // register indices
  localparam int IDX_CTRL     = 0;
  localparam int IDX_INJ      = 1;
  localparam int IDX_STAT     = 2;
  localparam int IDX_CAP_BASE = 4;
  // control bit positions
  localparam int CTRL_CMD_EN = 7;
  localparam int CTRL_IGN    = 4;
  localparam int CTRL_DBL_EN = 1;
  localparam int CTRL_SGL_EN = 0;
  // injection bit positions
  localparam int INJ_DBL = 1;
  localparam int INJ_SGL = 0;
  // status bit positions
  localparam int STAT_CMD = 7;
  localparam int STAT_DBL = 1;
  localparam int STAT_SGL = 0;

  typedef struct packed {
    logic cmd_en;
    logic ign_sgl;
    logic dbl_en;
    logic sgl_en;
    logic inj_dbl;
    logic inj_sgl;
  } ctrl_t;

  typedef struct packed {
    logic cmd;
    logic dbl;
    logic sgl;
  } flags_t;
endpackage

// File: rtl/ecc_rpt_ctrl_regs.sv
module ecc_rpt_ctrl_regs
  import ecc_rpt_pkg::*;
#(
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  output ctrl_t             ctrl_d,
  output ctrl_t             ctrl_q
);
  logic wr_ctrl, wr_inj;
  logic unused_wbits;

  assign wr_ctrl = wr_en && (wr_idx == RIDX_W'(IDX_CTRL));
  assign wr_inj  = wr_en && (wr_idx == RIDX_W'(IDX_INJ));
  assign unused_wbits = ^{wr_data[6:5], wr_data[3:2]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.cmd_en  = wr_data[CTRL_CMD_EN];
      ctrl_d.ign_sgl = wr_data[CTRL_IGN];
      ctrl_d.dbl_en  = wr_data[CTRL_DBL_EN];
      ctrl_d.sgl_en  = wr_data[CTRL_SGL_EN];
    end
    if (wr_inj) begin
      ctrl_d.inj_dbl = wr_data[INJ_DBL];
      ctrl_d.inj_sgl = wr_data[INJ_SGL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  AST_INJ_DBL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.inj_dbl && !wr_inj) |=> ctrl_q.inj_dbl); // R6
  AST_INJ_SGL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.inj_sgl && !wr_inj) |=> ctrl_q.inj_sgl); // R6
endmodule

// File: rtl/ecc_rpt_fault_track.sv
module ecc_rpt_fault_track
  import ecc_rpt_pkg::*;
#(
  parameter int CAP_AW = 16,
  parameter int CAP_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_q,
  input  logic              rd_valid,
  input  logic [CAP_AW-1:0] rd_addr,
  input  logic [CAP_DW-1:0] rd_data,
  input  logic              sgl_det,
  input  logic              dbl_det,
  input  logic              cmd_done,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  output flags_t            flags_d,
  output flags_t            flags_q,
  output logic [CAP_AW-1:0] cap_addr_q,
  output logic [CAP_DW-1:0] cap_data_q
);
  logic real_dbl, real_sgl, set_dbl, set_sgl;
  logic clr_cmd, clr_dbl, clr_sgl;
  logic cap_load, lock_d, lock_q;
  logic unused_ctrl;

  assign unused_ctrl = ^{ctrl_q.cmd_en, ctrl_q.dbl_en, ctrl_q.sgl_en,
                         stat_wdata[6:2]};

  // double detect wins over single detect on the same read
  assign real_dbl = rd_valid && dbl_det;
  assign real_sgl = rd_valid && sgl_det && !dbl_det && !ctrl_q.ign_sgl;
  assign set_dbl  = real_dbl || (rd_valid && ctrl_q.inj_dbl);
  assign set_sgl  = real_sgl || (rd_valid && ctrl_q.inj_sgl);

  assign clr_cmd = stat_wr && stat_wdata[STAT_CMD];
  assign clr_dbl = stat_wr && stat_wdata[STAT_DBL];
  assign clr_sgl = stat_wr && stat_wdata[STAT_SGL];

  always_comb begin
    flags_d.cmd = cmd_done || (flags_q.cmd && !clr_cmd);
    flags_d.dbl = set_dbl  || (flags_q.dbl && !clr_dbl);
    flags_d.sgl = set_sgl  || (flags_q.sgl && !clr_sgl);
  end

  // capture opens again once both fault flags are clear
  assign cap_load = (real_dbl || real_sgl) && !lock_q;
  assign lock_d   = (lock_q || cap_load) && (flags_d.dbl || flags_d.sgl);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      lock_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      flags_q <= flags_d;
      lock_q  <= lock_d;
      if (cap_load) begin
        cap_addr_q <= rd_addr;
        cap_data_q <= rd_data;
      end
    end
  end

  AST_INJ_DBL_SETS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ctrl_q.inj_dbl) |=> flags_q.dbl); // R6
  AST_IGNORED_SGL: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && sgl_det && ctrl_q.ign_sgl && !ctrl_q.inj_sgl && !stat_wr)
      |=> $stable(flags_q.sgl)); // R4
  AST_DBL_PRIO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && sgl_det && dbl_det && !ctrl_q.inj_sgl && !flags_q.sgl)
      |=> (flags_q.dbl && !flags_q.sgl)); // R5
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(cap_addr_q) && $stable(cap_data_q))); // R7
  AST_W1C_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_wdata[STAT_DBL] && flags_q.dbl) |=> flags_q.dbl); // R8
endmodule

// File: rtl/ecc_rpt_irq.sv
module ecc_rpt_irq
  import ecc_rpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t flags_d,
  input  ctrl_t  ctrl_d,
  input  flags_t flags_q,
  input  ctrl_t  ctrl_q,
  output logic   irq_cmd_o,
  output logic   irq_dbl_o,
  output logic   irq_sgl_o
);
  logic unused_inj;
  assign unused_inj = ^{ctrl_d.ign_sgl, ctrl_d.inj_dbl, ctrl_d.inj_sgl,
                        ctrl_q.ign_sgl, ctrl_q.inj_dbl, ctrl_q.inj_sgl};

  // registered from next-state so the level tracks flag and enable in step
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cmd_o <= 1'b0;
      irq_dbl_o <= 1'b0;
      irq_sgl_o <= 1'b0;
    end else begin
      irq_cmd_o <= flags_d.cmd && ctrl_d.cmd_en;
      irq_dbl_o <= flags_d.dbl && ctrl_d.dbl_en;
      irq_sgl_o <= flags_d.sgl && ctrl_d.sgl_en;
    end
  end

  AST_IRQ_CMD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_cmd_o == (flags_q.cmd && ctrl_q.cmd_en)); // R3
  AST_IRQ_DBL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_dbl_o == (flags_q.dbl && ctrl_q.dbl_en)); // R9
  AST_IRQ_SGL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_sgl_o == (flags_q.sgl && ctrl_q.sgl_en)); // R9
endmodule

// File: rtl/ecc_rpt_rdmux.sv
module ecc_rpt_rdmux
  import ecc_rpt_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int CAP_AW = 16,
  parameter int CAP_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rd_idx,
  input  ctrl_t             ctrl_q,
  input  flags_t            flags_q,
  input  logic [CAP_AW-1:0] cap_addr_q,
  input  logic [CAP_DW-1:0] cap_data_q,
  output logic [7:0]        rdata_o
);
  localparam int NAB  = (CAP_AW + 7) / 8;
  localparam int NDB  = (CAP_DW + 7) / 8;
  localparam int NCAP = NAB + NDB;

  logic [NAB*8-1:0] addr_pad;
  logic [NDB*8-1:0] data_pad;
  logic [7:0]       cap_byte [NCAP];
  logic [7:0]       rd_d;

  assign addr_pad = (NAB*8)'(cap_addr_q);
  assign data_pad = (NDB*8)'(cap_data_q);

  genvar g;
  generate
    for (g = 0; g < NAB; g++) begin : g_abyte
      assign cap_byte[g] = addr_pad[g*8 +: 8];
    end
    for (g = 0; g < NDB; g++) begin : g_dbyte
      assign cap_byte[NAB+g] = data_pad[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    if (rd_idx == RIDX_W'(IDX_CTRL)) begin
      rd_d[CTRL_CMD_EN] = ctrl_q.cmd_en;
      rd_d[CTRL_IGN]    = ctrl_q.ign_sgl;
      rd_d[CTRL_DBL_EN] = ctrl_q.dbl_en;
      rd_d[CTRL_SGL_EN] = ctrl_q.sgl_en;
    end else if (rd_idx == RIDX_W'(IDX_INJ)) begin
      rd_d[INJ_DBL] = ctrl_q.inj_dbl;
      rd_d[INJ_SGL] = ctrl_q.inj_sgl;
    end else if (rd_idx == RIDX_W'(IDX_STAT)) begin
      rd_d[STAT_CMD] = flags_q.cmd;
      rd_d[STAT_DBL] = flags_q.dbl;
      rd_d[STAT_SGL] = flags_q.sgl;
    end
    for (int i = 0; i < NCAP; i++) begin
      if (rd_idx == RIDX_W'(IDX_CAP_BASE + i)) rd_d = cap_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end
endmodule

// File: rtl/ecc_fault_reporter.sv
module ecc_fault_reporter
  import ecc_rpt_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int CAP_AW = 16,
  parameter int CAP_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RIDX_W-1:0] reg_widx,
  input  logic [7:0]        reg_wdata,
  input  logic [RIDX_W-1:0] reg_ridx,
  output logic [7:0]        reg_rdata,
  input  logic              arr_rd_valid,
  input  logic [CAP_AW-1:0] arr_rd_addr,
  input  logic [CAP_DW-1:0] arr_rd_data,
  input  logic              arr_sgl_det,
  input  logic              arr_dbl_det,
  input  logic              cmd_done,
  output logic              irq_cmd,
  output logic              irq_dbl,
  output logic              irq_sgl
);
  ctrl_t             ctrl_d, ctrl_q;
  flags_t            flags_d, flags_q;
  logic [CAP_AW-1:0] cap_addr_q;
  logic [CAP_DW-1:0] cap_data_q;
  logic              stat_wr;

  assign stat_wr = reg_wr && (reg_widx == RIDX_W'(IDX_STAT));

  ecc_rpt_ctrl_regs #(.RIDX_W(RIDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_idx(reg_widx),
    .wr_data(reg_wdata), .ctrl_d(ctrl_d), .ctrl_q(ctrl_q)
  );

  ecc_rpt_fault_track #(.CAP_AW(CAP_AW), .CAP_DW(CAP_DW)) u_track (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q),
    .rd_valid(arr_rd_valid), .rd_addr(arr_rd_addr), .rd_data(arr_rd_data),
    .sgl_det(arr_sgl_det), .dbl_det(arr_dbl_det), .cmd_done(cmd_done),
    .stat_wr(stat_wr), .stat_wdata(reg_wdata),
    .flags_d(flags_d), .flags_q(flags_q),
    .cap_addr_q(cap_addr_q), .cap_data_q(cap_data_q)
  );

  ecc_rpt_irq u_irq (
    .clk(clk), .rst(rst), .flags_d(flags_d), .ctrl_d(ctrl_d),
    .flags_q(flags_q), .ctrl_q(ctrl_q),
    .irq_cmd_o(irq_cmd), .irq_dbl_o(irq_dbl), .irq_sgl_o(irq_sgl)
  );

  ecc_rpt_rdmux #(.RIDX_W(RIDX_W), .CAP_AW(CAP_AW), .CAP_DW(CAP_DW)) u_rdmux (
    .clk(clk), .rst(rst), .rd_idx(reg_ridx), .ctrl_q(ctrl_q),
    .flags_q(flags_q), .cap_addr_q(cap_addr_q), .cap_data_q(cap_data_q),
    .rdata_o(reg_rdata)
  );
endmodule

// File: tb/ecc_fault_reporter_tb_top.sv
`timescale 1ns/1ps
module ecc_fault_reporter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [3:0]  reg_widx, reg_ridx;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        arr_rd_valid, arr_sgl_det, arr_dbl_det, cmd_done;
  logic [15:0] arr_rd_addr, arr_rd_data;
  logic        irq_cmd, irq_dbl, irq_sgl;

  always #2.5 clk = ~clk;

  ecc_fault_reporter dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_widx(reg_widx),
    .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
    .arr_rd_valid(arr_rd_valid), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .arr_sgl_det(arr_sgl_det),
    .arr_dbl_det(arr_dbl_det), .cmd_done(cmd_done),
    .irq_cmd(irq_cmd), .irq_dbl(irq_dbl), .irq_sgl(irq_sgl)
  );

  typedef struct {
    int         due;
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each queued item at the cycle it is due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {5'b0, irq_cmd, irq_dbl, irq_sgl} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s actual=%02h expected=%02h", it.tag,
                 it.is_irq ? "irq{cmd,dbl,sgl}" : "rdata", act, it.exp);
      end
    end
  end

  task automatic step(input logic wr, input logic [3:0] widx, input logic [7:0] wd,
                      input logic [3:0] ridx, input logic rv, input logic [15:0] ra,
                      input logic [15:0] rdd, input logic s, input logic d,
                      input logic cd);
    @(negedge clk);
    reg_wr = wr; reg_widx = widx; reg_wdata = wd; reg_ridx = ridx;
    arr_rd_valid = rv; arr_rd_addr = ra; arr_rd_data = rdd;
    arr_sgl_det = s; arr_dbl_det = d; cmd_done = cd;
  endtask

  task automatic push(input bit is_irq, input logic [7:0] exp, input string tag);
    item_t it;
    it.due = cyc + 1; it.is_irq = is_irq; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic exp_rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    step(0, 0, 0, idx, 0, 0, 0, 0, 0, 0);
    push(0, exp, tag);
  endtask
  task automatic exp_irq(input logic [2:0] exp, input string tag);
    idle();
    push(1, {5'b0, exp}, tag);
  endtask
  task automatic wr(input logic [3:0] idx, input logic [7:0] data);
    step(1, idx, data, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_irq(input logic [3:0] idx, input logic [7:0] data,
                        input logic [2:0] exp, input string tag);
    wr(idx, data);
    push(1, {5'b0, exp}, tag);
  endtask
  task automatic aread(input logic [15:0] a, input logic [15:0] dd,
                       input logic s, input logic d);
    step(0, 0, 0, 0, 1, a, dd, s, d, 0);
  endtask
  task automatic aread_irq(input logic [15:0] a, input logic [15:0] dd,
                           input logic s, input logic d, input logic [2:0] exp,
                           input string tag);
    aread(a, dd, s, d);
    push(1, {5'b0, exp}, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    reg_wr = 0; reg_widx = 0; reg_wdata = 0; reg_ridx = 0;
    arr_rd_valid = 0; arr_rd_addr = 0; arr_rd_data = 0;
    arr_sgl_det = 0; arr_dbl_det = 0; cmd_done = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 8; i++) exp_rd(4'(i), 8'h00, "R1");
    exp_irq(3'b000, "R1");

    // R2 register bits
    wr(0, 8'hFF); exp_rd(0, 8'h93, "R2");
    wr(1, 8'hFF); exp_rd(1, 8'h03, "R2");
    exp_rd(3, 8'h00, "R2");
    wr(1, 8'h00); wr(0, 8'h00); exp_rd(0, 8'h00, "R2");

    // R3 command complete
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    exp_rd(2, 8'h80, "R3");
    exp_irq(3'b000, "R3");
    wr_irq(0, 8'h80, 3'b100, "R3");
    wr_irq(2, 8'h80, 3'b000, "R3");
    exp_rd(2, 8'h00, "R8");

    // R4/R7 single fault and first capture
    wr(0, 8'h03);
    aread_irq(16'h1234, 16'hBEEF, 1, 0, 3'b001, "R4");
    exp_rd(2, 8'h01, "R4");
    exp_rd(4, 8'h34, "R7"); exp_rd(5, 8'h12, "R7");
    exp_rd(6, 8'hEF, "R7"); exp_rd(7, 8'hBE, "R7");
    aread(16'h5555, 16'hAAAA, 1, 0);
    exp_rd(4, 8'h34, "R7"); exp_rd(7, 8'hBE, "R7");
    wr(2, 8'h00); exp_rd(2, 8'h01, "R8");
    wr_irq(2, 8'h01, 3'b000, "R9");
    exp_rd(2, 8'h00, "R8");

    // R5 double priority
    aread_irq(16'h0A0B, 16'h0C0D, 1, 1, 3'b010, "R5");
    exp_rd(2, 8'h02, "R5");
    exp_rd(4, 8'h0B, "R7"); exp_rd(5, 8'h0A, "R7"); exp_rd(7, 8'h0C, "R7");
    wr_irq(2, 8'h02, 3'b000, "R9");

    // R4 ignore mode
    wr(0, 8'h13);
    aread_irq(16'h7777, 16'h7777, 1, 0, 3'b000, "R4");
    exp_rd(2, 8'h00, "R4");
    exp_rd(4, 8'h0B, "R4");

    // R6 forced double, R7 capture only on genuine fault
    wr(0, 8'h03); wr(1, 8'h02);
    aread_irq(16'h1111, 16'h1111, 0, 0, 3'b010, "R6");
    exp_rd(2, 8'h02, "R6");
    exp_rd(4, 8'h0B, "R7");
    exp_rd(1, 8'h02, "R6");
    aread(16'h2222, 16'h3333, 1, 0);
    exp_rd(2, 8'h03, "R7");
    exp_rd(5, 8'h22, "R7"); exp_rd(6, 8'h33, "R7");
    wr(2, 8'h03); wr(1, 8'h00);
    aread(16'h4444, 16'h4444, 0, 0);
    exp_rd(2, 8'h00, "R6");

    // R6 forced single overrides ignore
    wr(0, 8'h13); wr(1, 8'h01);
    aread(16'h0000, 16'h0000, 0, 0);
    exp_rd(2, 8'h01, "R6");
    wr(1, 8'h00); wr(2, 8'h01);

    // R8 set wins over same-cycle clear
    wr(0, 8'h03);
    aread(16'h0009, 16'h0009, 0, 1);
    step(1, 2, 8'h02, 0, 1, 16'h00F0, 16'h00F0, 0, 1, 0);
    exp_rd(2, 8'h02, "R8");
    exp_rd(4, 8'h09, "R7");
    wr(2, 8'h02); exp_rd(2, 8'h00, "R8");

    // R10 one-cycle read latency
    exp_rd(0, 8'h03, "R10");

    repeat (4) idle();
    done = 1'b1;
    finish_run();
  end
endmodule